// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns one parallel character into an asynchronous serial frame on a single output line. A producer offers a byte on a valid/ready handshake, together with four static settings: how many data bits to send, which parity to add, how long the stop period lasts, and whether the most or the least significant bit goes out first. An internal counter sets the bit period, taken from a parameter giving system clock cycles per bit. The same counter also marks half-bit points, which times a stop period of one and a half bits.

When it has no frame to send, the line sits at logic 1. After it accepts a byte, the block sends a low start bit, then the chosen data bits, then an optional parity bit, and then a high stop period. It raises a one-cycle done flag as the stop period ends, and in that same cycle it is ready again. The settings and the byte are captured when the byte is accepted, so changes on those inputs during a frame have no effect on it.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `line_out` is 1, `in_ready` is 1 and `frame_done` is 0.
- R2: In the cycle after a byte is accepted (`in_valid` and `in_ready` both high at a clock edge), `line_out` goes to 0 and stays there for one bit period of CLKS_PER_BIT cycles.
- R3: The data bit count follows `cfg_len`: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Each bit lasts CLKS_PER_BIT cycles and follows the start bit directly.
- R4: When `cfg_msb_first` is 0, the data bits go out from bit 0 upward. When it is 1, they go out from the highest active bit (bit count minus 1) down to bit 0.
- R5: The parity encoding on `cfg_parity` is 0 or 3 for none, 1 for odd and 2 for even. With odd parity, one extra bit after the data makes the number of ones across data and parity odd. With even parity it makes that number even. With no parity, the stop period follows the last data bit directly.
- R6: The stop period holds `line_out` at 1 for 2, 3 or 4 half-bit periods of CLKS_PER_BIT/2 cycles each, chosen by `cfg_stop` = 0 (1 bit), 1 (1.5 bits) or 2 and 3 (2 bits).
- R7: The byte and all settings are captured when the byte is accepted. Changes on `in_data`, `cfg_len`, `cfg_parity`, `cfg_stop` or `cfg_msb_first` during a frame do not alter that frame.
- R8: `in_ready` is 0 from the cycle after an accept until the stop period ends. A pulse on `in_valid` during that time starts no frame.
- R9: `frame_done` is high for exactly one cycle, which is the first cycle after the stop period. `in_ready` is 1 in that cycle.
- R10: Input bits above the selected character length are neither sent nor counted in the parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can accept a byte |
| in_data | input | 8 | Character; the low bits are used |
| cfg_len | input | 2 | Data bit count code (5 to 8) |
| cfg_parity | input | 2 | Parity mode code |
| cfg_stop | input | 2 | Stop period code |
| cfg_msb_first | input | 1 | 1 sends the highest active bit first |
| line_out | output | 1 | Serial line, idle high |
| frame_done | output | 1 | One-cycle pulse when the frame ends |

## Verification
The bench samples every bit at its centre and measures the exact cycle of the done pulse. A counter that is one cycle off, or a stop period built from whole bits only, therefore shows up as a misplaced pulse or a wrong length for the 1.5-bit stop. It sends 5-bit and 6-bit characters with their high input bits set. A design that masked the data but not the parity, or indexed MSB-first from bit 7, would send the wrong parity bit or data from outside the character. On every cycle of every frame the bench scrambles the byte and the settings, so a design that reads them live rather than captured would corrupt the frame. It also pulses the valid input partway through a frame, so a design that accepted while busy would start a second frame or clip the first.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int CLKS_PER_BIT = 868
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic [1:0] cfg_len,
  input  logic [1:0] cfg_parity,
  input  logic [1:0] cfg_stop,
  input  logic       cfg_msb_first,
  output logic       line_out,
  output logic       frame_done
);
  localparam int HALF = CLKS_PER_BIT / 2;
  localparam int CW = $clog2(CLKS_PER_BIT + 1);
  localparam logic [CW-1:0] BIT_LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [2:0]  idx, lenq, halves, stop_halves;
  logic [7:0]  dq;
  logic        parq, par_on, msbq;

  logic [7:0] mask;
  logic       sum;
  logic       accept, bit_end, half_end, cur;

  assign mask     = 8'hFF >> (2'd3 - cfg_len);
  assign sum      = ^(in_data & mask);
  assign in_ready = (st == S_IDLE);
  assign accept   = in_valid && in_ready;
  assign bit_end  = (cnt == BIT_LAST);
  assign half_end = (cnt == HALF_LAST);
  assign cur      = msbq ? dq[lenq - idx] : dq[idx];

  always_comb begin
    case (st)
      S_START: line_out = 1'b0;
      S_DATA:  line_out = cur;
      S_PAR:   line_out = parq;
      default: line_out = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      idx         <= '0;
      lenq        <= 3'd7;
      halves      <= '0;
      stop_halves <= 3'd2;
      dq          <= '0;
      parq        <= 1'b0;
      par_on      <= 1'b0;
      msbq        <= 1'b0;
      frame_done  <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          st          <= S_START;
          cnt         <= '0;
          idx         <= '0;
          halves      <= '0;
          dq          <= in_data & mask;
          lenq        <= {1'b1, cfg_len};
          msbq        <= cfg_msb_first;
          par_on      <= (cfg_parity == 2'd1) || (cfg_parity == 2'd2);
          parq        <= (cfg_parity == 2'd1) ? ~sum : sum;
          stop_halves <= (cfg_stop == 2'd0) ? 3'd2 : (cfg_stop == 2'd1) ? 3'd3 : 3'd4;
        end
        S_START: begin
          cnt <= bit_end ? '0 : cnt + 1'b1;
          if (bit_end) st <= S_DATA;
        end
        S_DATA: begin
          cnt <= bit_end ? '0 : cnt + 1'b1;
          if (bit_end) begin
            idx <= idx + 1'b1;
            if (idx == lenq) st <= par_on ? S_PAR : S_STOP;
          end
        end
        S_PAR: begin
          cnt <= bit_end ? '0 : cnt + 1'b1;
          if (bit_end) st <= S_STOP;
        end
        S_STOP: begin
          cnt <= half_end ? '0 : cnt + 1'b1;
          if (half_end) begin
            halves <= halves + 1'b1;
            if (halves + 1'b1 == stop_halves) begin
              st         <= S_IDLE;
              frame_done <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> line_out);
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> !line_out);
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  a_r9_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> in_ready);
  a_r7_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && $past(!in_ready)) |-> ($stable(lenq) && $stable(dq) && $stable(msbq)));
endmodule

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;
  localparam int CPB = 8;
  localparam int HB = CPB / 2;
  // {data[15:8], len[7:6], parity[5:4], stop[3:2], msb[1], expected parity[0]}
  localparam logic [15:0] VEC [9] = '{
    16'h41D1, 16'h41E6, 16'h5529, 16'hFF53, 16'hE099,
    16'hA5C6, 16'h00E0, 16'h1F12, 16'hC3FC };

  logic clk = 0, rst_n = 0, in_valid = 0, cfg_msb_first = 0;
  logic [7:0] in_data = 0;
  logic [1:0] cfg_len = 0, cfg_parity = 0, cfg_stop = 0;
  logic in_ready, line_out, frame_done;
  int total = 0, bad = 0;
  logic ln [200];
  logic rd [200];
  logic dn [200];

  always #5 clk = ~clk;

  uart_frame_tx #(.CLKS_PER_BIT(CPB)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_len(cfg_len), .cfg_parity(cfg_parity),
    .cfg_stop(cfg_stop), .cfg_msb_first(cfg_msb_first),
    .line_out(line_out), .frame_done(frame_done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic capture(input int n, input bit scramble, input int pulse_at);
    for (int c = 0; c < n; c++) begin
      ln[c] = line_out; rd[c] = in_ready; dn[c] = frame_done;
      in_valid = (c == pulse_at);
      if (scramble) begin
        in_data = 8'($urandom); cfg_len = 2'($urandom); cfg_parity = 2'($urandom);
        cfg_stop = 2'($urandom); cfg_msb_first = 1'($urandom);
      end
      @(negedge clk);
    end
    in_valid = 0;
  endtask

  task automatic run_vec(input logic [15:0] v);
    logic [7:0] d;
    int nd, nb, hv, t, b;
    bit po, ok;
    d = v[15:8];
    nd = 5 + int'(v[7:6]);
    po = (v[5:4] == 2'd1) || (v[5:4] == 2'd2);
    nb = 1 + nd + (po ? 1 : 0);
    hv = (v[3:2] == 2'd0) ? 2 : (v[3:2] == 2'd1) ? 3 : 4;
    t = nb * CPB + hv * HB;
    @(negedge clk);
    in_data = d; cfg_len = v[7:6]; cfg_parity = v[5:4]; cfg_stop = v[3:2];
    cfg_msb_first = v[1]; in_valid = 1;
    @(negedge clk);
    capture(t + 2, 1'b1, -1);
    chk(ln[CPB/2] == 1'b0, "R2 start bit", int'(ln[CPB/2]), 0);
    for (int i = 0; i < nd; i++) begin
      b = v[1] ? int'(d[nd-1-i]) : int'(d[i]);
      chk(ln[(1+i)*CPB + CPB/2] == 1'(b), "R3 R4 R7 R10 data bit",
          int'(ln[(1+i)*CPB + CPB/2]), b);
    end
    if (po) chk(ln[(1+nd)*CPB + CPB/2] == v[0], "R5 R10 parity bit",
                int'(ln[(1+nd)*CPB + CPB/2]), int'(v[0]));
    ok = 1;
    for (int c = nb * CPB; c < t; c++) if (!ln[c] || rd[c] || dn[c]) ok = 0;
    chk(ok, "R6 R8 stop period high and busy", int'(ok), 1);
    chk(dn[t] && rd[t] && !dn[t+1], "R9 done pulse timing",
        int'({dn[t], rd[t], dn[t+1]}), 3'b110);
  endtask

  initial begin
    #3000000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #23;
    chk(line_out && in_ready && !frame_done, "R1 reset state",
        int'({line_out, in_ready, frame_done}), 3'b110);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    chk(line_out && in_ready && !frame_done, "R1 idle after reset",
        int'({line_out, in_ready, frame_done}), 3'b110);

    foreach (VEC[k]) run_vec(VEC[k]);

    // R8: valid pulse mid-frame must not start a new frame
    @(negedge clk);
    in_data = 8'h00; cfg_len = 2'd3; cfg_parity = 2'd0; cfg_stop = 2'd0;
    cfg_msb_first = 0; in_valid = 1;
    @(negedge clk);
    in_data = 8'hFF;
    capture(10 * CPB + 30, 1'b0, 20);
    chk(ln[2*CPB + CPB/2] == 1'b0, "R8 data unaffected by busy valid",
        int'(ln[2*CPB + CPB/2]), 0);
    chk(dn[10*CPB], "R8 original frame ends on time", int'(dn[10*CPB]), 1);
    begin
      bit ok = 1;
      for (int c = 10 * CPB; c < 10 * CPB + 30; c++) if (!ln[c] || !rd[c]) ok = 0;
      for (int c = 10 * CPB + 1; c < 10 * CPB + 30; c++) if (dn[c]) ok = 0;
      chk(ok, "R8 R1 no second frame, line idle high", int'(ok), 1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule